// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block is the control sequencer of a small Harvard-style processor. The processor shares its memories with a video fetcher. The master clock is split into four phases, and the processor and the video engine take turns on them. While the processor owns the program ROM, the fetcher owns the RAM, and the other way round, so both memories are busy in every phase.

A process cycle walks through fetch (program ROM at the program counter), read (indexed RAM access), execute (ROM again, for an inline immediate or as a nibble-wide lookup-table ALU) and write (register update, optionally RAM). The number of process cycles per instruction depends on its kind:

- A 16-bit instruction needs a second fetch cycle for its offset byte.
- A byte-wide ALU operation needs one lookup pass per nibble.
- A NOP, or a conditional load whose condition is false, finishes in one cycle with no execute access.

The ROM and RAM are outside the block. Their read data returns combinationally within the phase that addresses them.

Top module: `fourphase_seq`

## Requirements
- R1: `phase` advances by one every clock, in the order fetch=0, read=1, execute=2, write=3, and wraps from 3 back to 0. Reset puts it at 0.
- R2: `rom_cpu_sel` is high in phases 0 and 2, and `ram_cpu_sel` is high in phases 1 and 3. `rom_rd` is only asserted while the processor owns the ROM. `ram_rd` and `ram_we` are only asserted while it owns the RAM.
- R3: After reset, `pc`, `acc` and `x` are zero and `op_fetch` is high, so the first opcode comes from ROM address 0.
- R4: An opcode with bits [7:6]=00 is a NOP. It takes one process cycle, advances `pc` by 1 and makes no execute-phase ROM read.
- R5: Class 01 with bit4=0 is an immediate load. It takes one process cycle, and in the execute phase it reads the byte at `pc` (the byte after the opcode). Bit3 selects the destination (0 = `acc`, 1 = `x`), and `pc` advances by 2.
- R6: Class 01 with bit5=1 is conditional, and `cond_in` is sampled in the read phase of its first cycle. When `cond_in` is low, the instruction takes exactly one process cycle, makes no execute-phase ROM read, changes no register, and advances `pc` by 2. This holds for both operand sources.
- R7: Class 01 with bit4=1 is a 16-bit indexed load. Its second cycle fetches an offset byte and reads RAM at `x`+offset (modulo 256) in the read phase, then loads the destination. It takes 2 cycles and advances `pc` by 2.
- R8: Class 10 is an ALU operation with function code bits[3:0], operand b = RAM[`x`] and a = `acc`. The low nibbles go through first and the high nibbles in a second cycle. The lookup address is {1, function, b nibble, a nibble}, and the result is ROM data bits [3:0]. `acc` receives {high, low} at the end of the second cycle, with no carry between nibbles. It advances `pc` by 1.
- R9: An ALU operation with bit5=1 also writes its 8-bit result to RAM[`x`] in the write phase of its second cycle.
- R10: Class 11 is a 16-bit store. In the write phase of its second cycle it writes `acc` to RAM at `x`+offset. It takes 2 cycles and advances `pc` by 2.
- R11: `op_fetch` marks phase 0 of an instruction's first cycle, and `pc` is one higher on the next clock. A program fetch happens in phase 0 of every cycle except the second ALU pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_in | input | 1 | Condition flag for conditional loads |
| rom_addr | output | PC_W+1 | ROM address: {0,pc} or lookup address |
| rom_rd | output | 1 | Processor reads ROM this phase |
| rom_data | input | 8 | ROM read data |
| ram_addr | output | RAM_AW | Indexed RAM address |
| ram_rd | output | 1 | Processor reads RAM this phase |
| ram_we | output | 1 | Processor writes RAM this phase |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| rom_cpu_sel | output | 1 | ROM owned by processor (else video) |
| ram_cpu_sel | output | 1 | RAM owned by processor (else video) |
| phase | output | 2 | Current phase |
| op_fetch | output | 1 | Opcode fetch of a new instruction |
| pc | output | PC_W | Program counter |
| acc | output | 8 | Accumulator |
| x | output | 8 | Index register |

## Verification
The bench builds the block with PC_W=12, the smallest width whose upper half holds the whole 12-bit lookup field, and RAM_AW=8, so that every indexed sum wraps inside one page. The 256-byte program image is aliased across the ROM's program half. This lets a run of several hundred random opcodes step the counter well past the image without running out of code. At every instruction boundary the bench compares the clock count, the number of fetch-phase and execute-phase ROM reads, the registers and the whole RAM page against an instruction-level model. Directed opcodes at the start cover both skipped load sources, the cross-nibble case of the add table and the store/reload path.

// File: rtl/fourphase_seq.sv
module fourphase_seq #(
  parameter int PC_W   = 12,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cond_in,
  output logic [PC_W:0]     rom_addr,
  output logic              rom_rd,
  input  logic [7:0]        rom_data,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              rom_cpu_sel,
  output logic              ram_cpu_sel,
  output logic [1:0]        phase,
  output logic              op_fetch,
  output logic [PC_W-1:0]   pc,
  output logic [7:0]        acc,
  output logic [7:0]        x
);

  localparam logic [1:0] PH_FETCH = 2'd0;
  localparam logic [1:0] PH_READ  = 2'd1;
  localparam logic [1:0] PH_EXEC  = 2'd2;
  localparam logic [1:0] PH_WRITE = 2'd3;

  localparam logic [1:0] ST_OP  = 2'd0;
  localparam logic [1:0] ST_ARG = 2'd1;
  localparam logic [1:0] ST_HI  = 2'd2;

  localparam logic [1:0] C_NOP = 2'd0;
  localparam logic [1:0] C_LD  = 2'd1;
  localparam logic [1:0] C_ALU = 2'd2;
  localparam logic [1:0] C_ST  = 2'd3;

  logic [1:0] stage;
  logic [7:0] ir, opnd, opb, res;
  logic [3:0] lo, hi;
  logic       ok;

  logic [1:0] cls;
  logic       in_op, in_arg, in_hi;
  logic       exec_imm, exec_alu;
  logic [3:0] b_nib, a_nib;
  logic [PC_W:0] lut_addr;
  logic [7:0] ea;

  assign cls    = ir[7:6];
  assign in_op  = (stage == ST_OP);
  assign in_arg = (stage == ST_ARG);
  assign in_hi  = (stage == ST_HI);

  assign b_nib    = in_hi ? opb[7:4] : opb[3:0];
  assign a_nib    = in_hi ? acc[7:4] : acc[3:0];
  assign lut_addr = {1'b1, PC_W'({ir[3:0], b_nib, a_nib})};

  assign exec_imm = (phase == PH_EXEC) && in_op && (cls == C_LD) && !ir[4] && ok;
  assign exec_alu = (phase == PH_EXEC) && ((in_op && cls == C_ALU) || in_hi);

  assign rom_cpu_sel = ~phase[0];
  assign ram_cpu_sel = phase[0];

  assign rom_rd   = ((phase == PH_FETCH) && !in_hi) || exec_imm || exec_alu;
  assign rom_addr = exec_alu ? lut_addr : {1'b0, pc};

  assign ea        = in_arg ? (x + opnd) : x;
  assign ram_addr  = RAM_AW'(ea);
  assign ram_rd    = (phase == PH_READ) &&
                     ((in_op && cls == C_ALU) || (in_arg && cls == C_LD));
  assign ram_we    = (phase == PH_WRITE) &&
                     ((in_arg && cls == C_ST) || (in_hi && ir[5]));
  assign ram_wdata = in_hi ? {hi, lo} : acc;

  assign op_fetch = (phase == PH_FETCH) && in_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      stage <= ST_OP;
      pc    <= '0;
      acc   <= '0;
      x     <= '0;
      ir    <= '0;
      opnd  <= '0;
      opb   <= '0;
      res   <= '0;
      lo    <= '0;
      hi    <= '0;
      ok    <= 1'b0;
    end else begin
      phase <= phase + 2'd1;
      case (phase)
        PH_FETCH: begin
          if (!in_hi) begin
            pc <= pc + 1'b1;
            if (in_op) ir <= rom_data;
            else       opnd <= rom_data;
          end
        end
        PH_READ: begin
          if (in_op) begin
            ok <= ~ir[5] | cond_in;
            if (cls == C_ALU) opb <= ram_rdata;
          end
          if (in_arg && cls == C_LD) res <= ram_rdata;
        end
        PH_EXEC: begin
          if (exec_imm) res <= rom_data;
          if (exec_alu) begin
            if (in_hi) hi <= rom_data[3:0];
            else       lo <= rom_data[3:0];
          end
        end
        default: begin
          case (stage)
            ST_OP: begin
              case (cls)
                C_LD: begin
                  if (!ok) begin
                    pc <= pc + 1'b1;
                  end else if (ir[4]) begin
                    stage <= ST_ARG;
                  end else begin
                    pc <= pc + 1'b1;
                    if (ir[3]) x <= res;
                    else       acc <= res;
                  end
                end
                C_ALU:   stage <= ST_HI;
                C_ST:    stage <= ST_ARG;
                default: stage <= ST_OP;
              endcase
            end
            ST_ARG: begin
              if (cls == C_LD) begin
                if (ir[3]) x <= res;
                else       acc <= res;
              end
              stage <= ST_OP;
            end
            default: begin
              acc   <= {hi, lo};
              stage <= ST_OP;
            end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/fourphase_seq_chk.sv
module fourphase_seq_chk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      phase,
  input logic            op_fetch,
  input logic            rom_rd,
  input logic            rom_cpu_sel,
  input logic            ram_rd,
  input logic            ram_we,
  input logic            ram_cpu_sel,
  input logic [PC_W-1:0] pc
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (phase == 2'($past(phase) + 2'd1)));

  p_rom_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> rom_cpu_sel);

  p_ram_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_we) |-> ram_cpu_sel);

  p_ram_read_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |-> (phase == 2'd1));

  p_ram_write_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (phase == 2'd3));

  p_fetch_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_fetch |-> (phase == 2'd0 && rom_rd));

  p_pc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_fetch |=> (pc == PC_W'($past(pc) + 1'b1)));

endmodule

bind fourphase_seq fourphase_seq_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase), .op_fetch(op_fetch),
  .rom_rd(rom_rd), .rom_cpu_sel(rom_cpu_sel), .ram_rd(ram_rd),
  .ram_we(ram_we), .ram_cpu_sel(ram_cpu_sel), .pc(pc)
);

// File: tb/fourphase_seq_tb_top.sv
`timescale 1ns/1ps
module fourphase_seq_tb_top;
  localparam int PC_W   = 12;
  localparam int RAM_AW = 8;
  localparam int NINS   = 700;
  localparam int NDIR   = 9;

  logic clk = 1'b0, rst_n = 1'b0, cond_in = 1'b0;
  logic [PC_W:0] rom_addr;
  logic rom_rd, ram_rd, ram_we, rom_cpu_sel, ram_cpu_sel, op_fetch;
  logic [7:0] rom_data, ram_rdata, ram_wdata, acc, x;
  logic [RAM_AW-1:0] ram_addr;
  logic [1:0] phase;
  logic [PC_W-1:0] pc;

  logic [7:0] prog [256];
  logic [7:0] mem  [256];
  logic [7:0] mref [256];
  bit dir_cond [NDIR] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  int checks = 0, fails = 0;
  bit done = 0;
  int mpc;
  logic [7:0] ma, mx;

  always #2 clk = ~clk;

  function automatic logic [3:0] lutf(input logic [3:0] f, input logic [3:0] b, input logic [3:0] a);
    case (f[1:0])
      2'd0: return 4'(a + b);
      2'd1: return a ^ b;
      2'd2: return a & b;
      default: return b;
    endcase
  endfunction

  assign rom_data  = rom_addr[PC_W] ? {4'h0, lutf(rom_addr[11:8], rom_addr[7:4], rom_addr[3:0])}
                                    : prog[rom_addr[7:0]];
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  fourphase_seq #(.PC_W(PC_W), .RAM_AW(RAM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cond_in(cond_in),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rom_cpu_sel(rom_cpu_sel), .ram_cpu_sel(ram_cpu_sel),
    .phase(phase), .op_fetch(op_fetch), .pc(pc), .acc(acc), .x(x)
  );

  task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input bit c, output int len, output int eex, output int efe, output string tag);
    logic [7:0] op, nb, b, r;
    bit good;
    op = prog[mpc & 255];
    nb = prog[(mpc + 1) & 255];
    good = !op[5] || c;
    case (op[7:6])
      2'd0: begin len = 1; eex = 0; efe = 1; tag = "R4"; mpc += 1; end
      2'd1: begin
        if (!good) begin
          len = 1; eex = 0; efe = 1; tag = "R6";
        end else if (!op[4]) begin
          len = 1; eex = 1; efe = 1; tag = "R5";
          if (op[3]) mx = nb; else ma = nb;
        end else begin
          len = 2; eex = 0; efe = 2; tag = "R7";
          r = mref[8'(mx + nb)];
          if (op[3]) mx = r; else ma = r;
        end
        mpc += 2;
      end
      2'd2: begin
        b = mref[mx];
        r = {lutf(op[3:0], b[7:4], ma[7:4]), lutf(op[3:0], b[3:0], ma[3:0])};
        ma = r;
        if (op[5]) mref[mx] = r;
        len = 2; eex = 2; efe = 1; tag = op[5] ? "R9" : "R8";
        mpc += 1;
      end
      default: begin
        mref[8'(mx + nb)] = ma;
        len = 2; eex = 0; efe = 2; tag = "R10";
        mpc += 2;
      end
    endcase
    mpc &= (1 << PC_W) - 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h4F51_A2C7));
    for (int i = 0; i < 256; i++) begin
      prog[i] = 8'($urandom);
      mem[i]  = 8'(i * 7 + 3);
      mref[i] = 8'(i * 7 + 3);
    end
    prog[0]  = 8'b0100_0000; prog[1]  = 8'h5A;
    prog[2]  = 8'b0110_1000; prog[3]  = 8'h33;
    prog[4]  = 8'b0110_1000; prog[5]  = 8'h07;
    prog[6]  = 8'b1100_0000; prog[7]  = 8'h03;
    prog[8]  = 8'b0111_0000; prog[9]  = 8'h03;
    prog[10] = 8'b0101_1000; prog[11] = 8'h03;
    prog[12] = 8'b0000_0000;
    prog[13] = 8'b1010_0000;
    prog[14] = 8'b1000_0001;
    mpc = 0; ma = 8'h00; mx = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(pc == '0,        "R3", "pc",       int'(pc),    0);
    chk(acc == 8'h00,    "R3", "acc",      int'(acc),   0);
    chk(x == 8'h00,      "R3", "x",        int'(x),     0);
    chk(phase == 2'd0,   "R3", "phase",    int'(phase), 0);
    chk(op_fetch == 1'b1, "R3", "op_fetch", int'(op_fetch), 1);

    for (int k = 0; k < NINS; k++) begin
      bit c;
      int len, eex, efe, n, ex, fe;
      string tag;
      c = (k < NDIR) ? dir_cond[k] : 1'($urandom_range(0, 1));
      cond_in = c;
      model(c, len, eex, efe, tag);
      n = 0; ex = 0; fe = 0;
      do begin
        chk(phase == 2'(n % 4), "R1", "phase", int'(phase), n % 4);
        chk(rom_cpu_sel == (phase == 2'd0 || phase == 2'd2) &&
            ram_cpu_sel == (phase == 2'd1 || phase == 2'd3),
            "R2", "owner", int'({rom_cpu_sel, ram_cpu_sel}), int'(phase));
        if (rom_rd && phase == 2'd0) fe++;
        if (rom_rd && phase == 2'd2) ex++;
        @(negedge clk);
        n++;
      end while (!op_fetch && n < 40);
      chk(n == 4 * len,          tag,   "clocks",      n,         4 * len);
      chk(ex == eex,             tag,   "exec reads",  ex,        eex);
      chk(fe == efe,             "R11", "fetch reads", fe,        efe);
      chk(int'(pc) == mpc,       tag,   "pc",          int'(pc),  mpc);
      chk(acc == ma,             tag,   "acc",         int'(acc), int'(ma));
      chk(x == mx,               tag,   "x",           int'(x),   int'(mx));
      begin
        int bad;
        bad = -1;
        for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== mref[i]) bad = i;
        chk(bad < 0, tag, "ram page", (bad < 0) ? 0 : int'(mem[bad]),
            (bad < 0) ? 0 : int'(mref[bad]));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule